// File: doc/BRIEF.md
# Manchester II Line Decoder with Sync Qualification

The block receives a Manchester II coded serial line and returns the NRZ bit stream together with a 1X recovered bit clock. The line arrives either as a complementary two-wire pair or as one single-ended wire. A fast system clock oversamples the line. Every line transition re-centres a half-bit phase counter, so that the counter takes one sample in the middle of each half-bit. A six-deep history of these half-bit samples finds the two sync shapes. Each pair of half-bit samples that follows a sync is decoded as one bit.

A code-valid flag marks when the output stream can be trusted. It rises only once a sync and two good bits have been seen. It falls on any coding fault, and decoding then stops until the next sync. A serial-reset output either mirrors the block reset (converter mode) or is driven by the first bit of each frame (repeater mode). A sync-type output reports whether the last sync was a command or a data sync.

Top module: `manchester_rx`

## Requirements
- R1: The line level is the OR of `pair_one` and `single_line`. In single-wire use, `pair_zero` is held 1, `pair_one` is held 0, and data is on `single_line`. In pair use, `single_line` is held 0, data is on `pair_one`, and `pair_zero` carries its complement. Frames decode the same way through either input.
- R2: A bit is sent as two half-bits of HALF_CYC clock cycles each: a one is high then low, and a zero is low then high. For each decoded bit, `rx_clk` rises once and `nrz_data` holds the bit value while `rx_clk` stays high (one half-bit high, one half-bit low).
- R3: A command sync is three half-bits high followed by three half-bits low. A data sync is three half-bits low followed by three half-bits high. Bits are decoded only after one of these shapes; two-half-bit runs do not start decoding.
- R4: While `rst_n` is low, `nrz_data`, `rx_clk`, `code_ok`, `link_rst_n` and `cmd_sync` are all 0, without waiting for a clock edge.
- R5: `code_ok` is 0 after reset and after any fault. It goes to 1 in the same cycle as the `rx_clk` rise of the second good bit after a sync.
- R6: A bit whose two halves have the same level drops `code_ok` to 0. No further bits are output until the next sync.
- R7: Equal levels on `pair_zero` and `pair_one` at a half-bit sample point act like R6.
- R8: With `repeat_mode` = 0, `link_rst_n` equals `rst_n` and `cmd_sync` is 0.
- R9: With `repeat_mode` = 1, `link_rst_n` is 0 from reset on. It becomes 1 when the first bit after a sync decodes as 0, and returns to 0 when that first bit decodes as 1.
- R10: With `repeat_mode` = 1, `cmd_sync` is 1 after a command sync and 0 after a data sync, and holds that value until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, HALF_CYC cycles per half-bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| repeat_mode | input | 1 | 0 converter, 1 repeater |
| pair_zero | input | 1 | Complement wire of the two-wire input |
| pair_one | input | 1 | True wire of the two-wire input |
| single_line | input | 1 | Single-ended line input |
| nrz_data | output | 1 | Decoded NRZ bit |
| rx_clk | output | 1 | Recovered 1X bit clock |
| code_ok | output | 1 | Decoded stream valid |
| link_rst_n | output | 1 | Serial reset, active low |
| cmd_sync | output | 1 | Type of the last sync, 1 for command |

## Verification
A phase counter that drifts off the half-bit centres shows up within one bit time. One symptom is a missing `rx_clk` pulse. Another is `code_ok` falling in the middle of a clean frame. A wrong half-bit pairing shows up as inverted `nrz_data` or as a fault on the first bit after the sync. Errors in the frame-start or good-bit bookkeeping show up on `code_ok` at the first or second bit, and on `link_rst_n` at the first bit. A sync-type error shows on `cmd_sync` by the end of the frame.

// File: rtl/manchester_rx.sv
module manchester_rx #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic repeat_mode,
  input  logic pair_zero,
  input  logic pair_one,
  input  logic single_line,
  output logic nrz_data,
  output logic rx_clk,
  output logic code_ok,
  output logic link_rst_n,
  output logic cmd_sync
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST_POS = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] MID_POS  = CW'(HALF_CYC / 2);
  localparam logic [5:0] CMD_PAT  = 6'b111000;
  localparam logic [5:0] DAT_PAT  = 6'b000111;
  localparam logic [5:0] HIST_RST = 6'b010101;

  logic [1:0] line_sy, bad_sy;
  logic ln, ln_d;
  logic [CW-1:0] ph, pos;
  logic [5:0] hs, hs_nx;
  logic strobe, illegal, sync_hit, sync_cmd_hit;
  logic in_frame, hp, first, first_bit, got_bit, type_q, srst_q;

  assign ln           = line_sy[1];
  assign pos          = (ln != ln_d || ph == LAST_POS) ? '0 : ph + CW'(1);
  assign strobe       = pos == MID_POS;
  assign illegal      = strobe & bad_sy[1];
  assign hs_nx        = {hs[4:0], ln};
  assign sync_cmd_hit = strobe && hs_nx == CMD_PAT;
  assign sync_hit     = sync_cmd_hit || (strobe && hs_nx == DAT_PAT);
  assign link_rst_n   = repeat_mode ? srst_q : rst_n;
  assign cmd_sync     = repeat_mode & type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_sy <= '0;
      bad_sy  <= '0;
      ln_d    <= 1'b0;
      ph      <= '0;
      hs      <= HIST_RST;
    end else begin
      line_sy <= {line_sy[0], pair_one | single_line};
      bad_sy  <= {bad_sy[0], pair_one ~^ pair_zero};
      ln_d    <= ln;
      ph      <= pos;
      if (strobe) hs <= hs_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame  <= 1'b0;
      hp        <= 1'b0;
      first     <= 1'b0;
      first_bit <= 1'b0;
      got_bit   <= 1'b0;
      type_q    <= 1'b0;
      srst_q    <= 1'b0;
      nrz_data  <= 1'b0;
      rx_clk    <= 1'b0;
      code_ok   <= 1'b0;
    end else if (illegal) begin
      in_frame <= 1'b0;
      hp       <= 1'b0;
      code_ok  <= 1'b0;
      rx_clk   <= 1'b0;
    end else if (sync_hit) begin
      in_frame  <= 1'b1;
      hp        <= 1'b0;
      first_bit <= 1'b1;
      got_bit   <= 1'b0;
      type_q    <= sync_cmd_hit;
      rx_clk    <= 1'b0;
    end else if (strobe) begin
      rx_clk <= 1'b0;
      if (in_frame) begin
        if (!hp) begin
          first <= ln;
          hp    <= 1'b1;
        end else begin
          hp <= 1'b0;
          if (first != ln) begin
            nrz_data  <= first;
            rx_clk    <= 1'b1;
            first_bit <= 1'b0;
            got_bit   <= 1'b1;
            if (first_bit) srst_q <= ~first;
            if (got_bit) code_ok <= 1'b1;
          end else begin
            in_frame <= 1'b0;
            code_ok  <= 1'b0;
          end
        end
      end
    end
  end

  assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clk && $past(rx_clk)) |-> $stable(nrz_data));

  assert_valid_with_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_ok) |-> $rose(rx_clk));

  assert_clk_only_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_clk) |-> $past(in_frame));

  assert_illegal_ends_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (!in_frame && !code_ok));

  assert_srst_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (repeat_mode && $past(repeat_mode) && $rose(link_rst_n)) |-> ($rose(rx_clk) && !nrz_data));

  assert_type_on_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (repeat_mode && $past(repeat_mode) && cmd_sync != $past(cmd_sync)) |-> $past(sync_hit));
endmodule

// File: tb/manchester_rx_tb.sv
module manchester_rx_tb;
  localparam int HALF_CYC = 4;
  // {repeat_mode, single_wire, command_sync, fault[1:0], bits[3:0]}, bits[0] sent first
  // fault: 0 none, 1 bit 2 without mid-bit transition, 2 equal pair levels in bit 2
  localparam logic [8:0] VEC [0:8] = '{
    9'b0_1_1_00_0110,
    9'b0_0_0_00_1001,
    9'b1_1_1_00_0101,
    9'b1_0_0_00_1110,
    9'b1_1_1_00_0011,
    9'b1_0_1_01_0010,
    9'b0_0_0_10_0111,
    9'b1_1_0_00_1000,
    9'b1_0_1_00_1111
  };

  logic clk = 1'b0;
  logic rst_n, repeat_mode, pair_zero, pair_one, single_line, cur_uni;
  logic nrz_data, rx_clk, code_ok, link_rst_n, cmd_sync;
  int n_cmp = 0, n_bad = 0, n_ev = 0;
  logic ev_d [8];
  logic ev_v [8];
  logic clk_seen = 1'b0;

  always #5 clk = ~clk;

  manchester_rx #(.HALF_CYC(HALF_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .repeat_mode(repeat_mode),
    .pair_zero(pair_zero), .pair_one(pair_one), .single_line(single_line),
    .nrz_data(nrz_data), .rx_clk(rx_clk), .code_ok(code_ok),
    .link_rst_n(link_rst_n), .cmd_sync(cmd_sync));

  always @(negedge clk) begin
    if (rx_clk && !clk_seen) begin
      if (n_ev < 8) begin
        ev_d[n_ev] = nrz_data;
        ev_v[n_ev] = code_ok;
      end
      n_ev = n_ev + 1;
    end
    clk_seen = rx_clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_half(input logic lvl, input logic bad);
    if (cur_uni) begin
      single_line = lvl; pair_zero = 1'b1; pair_one = 1'b0;
    end else begin
      single_line = 1'b0; pair_one = lvl; pair_zero = !lvl;
    end
    if (bad) begin
      pair_zero = 1'b1; pair_one = 1'b1;
    end
    repeat (HALF_CYC) @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input logic [8:0] v);
    logic md, cmd;
    logic [1:0] err;
    logic [3:0] d;
    int ne;
    md = v[8]; cmd = v[6]; err = v[5:4]; d = v[3:0];
    repeat_mode = md;
    cur_uni = v[7];
    for (int i = 0; i < 4; i++) put_half(cmd, 1'b0);
    chk("R5", int'(code_ok), 0);
    n_ev = 0;
    for (int i = 0; i < 3; i++) put_half(cmd, 1'b0);
    for (int i = 0; i < 3; i++) put_half(!cmd, 1'b0);
    for (int k = 0; k < 4; k++) begin
      if (err == 2'd1 && k == 2) begin
        put_half(1'b1, 1'b0);
        put_half(1'b1, 1'b0);
      end else begin
        put_half(d[k], err == 2'd2 && k == 2);
        put_half(!d[k], 1'b0);
      end
    end
    put_half(!d[3], 1'b0);
    ne = (err == 2'd0) ? 4 : 2;
    chk(err == 2'd0 ? "R1" : (err == 2'd1 ? "R6" : "R7"), n_ev, ne);
    for (int k = 0; k < ne; k++) begin
      chk("R2", int'(ev_d[k]), int'(d[k]));
      chk("R5", int'(ev_v[k]), (k >= 1) ? 1 : 0);
    end
    chk(err == 2'd0 ? "R5" : (err == 2'd1 ? "R6" : "R7"), int'(code_ok), (err == 2'd0) ? 1 : 0);
    chk(md ? "R10" : "R8", int'(cmd_sync), md ? int'(cmd) : 0);
    chk(md ? "R9" : "R8", int'(link_rst_n), md ? int'(!d[0]) : 1);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; repeat_mode = 1'b0; cur_uni = 1'b1;
    single_line = 1'b1; pair_zero = 1'b1; pair_one = 1'b0;
    #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R4", int'({nrz_data, rx_clk, code_ok, link_rst_n, cmd_sync}), 0);
    rst_n = 1'b1;
    #1;
    chk("R8", int'(link_rst_n), 1);
    chk("R5", int'(code_ok), 0);

    for (int i = 0; i < 9; i++) run_frame(VEC[i]);

    // reset while outputs are active, repeater mode
    rst_n = 1'b0;
    #2;
    chk("R4", int'({nrz_data, rx_clk, code_ok, link_rst_n, cmd_sync}), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", int'(link_rst_n), 0);
    chk("R5", int'(code_ok), 0);

    // runs of two half-bits are not a sync (R3)
    cur_uni = 1'b1;
    for (int i = 0; i < 4; i++) put_half(1'b0, 1'b0);
    n_ev = 0;
    put_half(1'b1, 1'b0); put_half(1'b1, 1'b0);
    put_half(1'b0, 1'b0); put_half(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      put_half(k[0] ? 1'b0 : 1'b1, 1'b0);
      put_half(k[0] ? 1'b1 : 1'b0, 1'b0);
    end
    chk("R3", n_ev, 0);
    chk("R3", int'(code_ok), 0);

    // first bit one keeps serial reset low, then a zero releases it (R9)
    run_frame(9'b1_1_1_00_0101);
    run_frame(9'b1_0_0_00_1110);

    // converter mode follows reset directly (R8)
    repeat_mode = 1'b0;
    rst_n = 1'b0;
    #2;
    chk("R4", int'(link_rst_n), 0);
    rst_n = 1'b1;
    #1;
    chk("R8", int'(link_rst_n), 1);
    chk("R8", int'(cmd_sync), 0);

    finish_run();
  end
endmodule